// File: doc/BRIEF.md
# Machine-Cycle Bus Strobe Timer

This block turns a fast oscillator clock into a steady train of machine cycles, each `CYC_LEN` clocks long (twelve by default). Every cycle carries at most one external bus transaction: a code fetch, a data read or a data write. The block sequences the strobes for that transaction on a bus whose low address byte and data byte share the same pins. During the first part of the cycle it places the low address byte on those pins and raises the address latch strobe, so that an external latch can capture the byte. Once the strobe drops, it uses the same pins for data.

Requests arrive on a valid/ready stream. `req_ready` is high for exactly one clock per machine cycle, in the last phase. A request must hold `req_valid` and its payload steady until it sees `req_ready`. The accepted request runs in the next machine cycle. A cycle with no accepted request is idle, and the latch strobe still pulses. Read and fetch results come back on `rsp_valid`/`rsp_data` as a single-clock pulse with no back-pressure, so the consumer must take the byte in that clock.

The shared pins are split into `ad_out`, `ad_oe` and `ad_in` so that the pad ring can build the bidirectional buffer.

Top module: `bus_cycle_timer`

## Requirements
- R1: A machine cycle lasts `CYC_LEN` clocks, numbered phase 0 to `CYC_LEN-1`. `req_ready` is high only in the last phase. A request accepted at that edge occupies the whole next cycle.
- R2: `ale` is high in phases 0 and 1 and in phases 6 and 7, and low in all other phases. This gives two pulses per cycle, one every six clocks, high for four of twelve phases. The pulses occur in idle cycles too.
- R3: In phases 0 and 1 of a cycle that carries a transaction, `ad_oe` is 1 and `ad_out` is the low address byte. `addr_hi` shows the high address byte for the whole cycle.
- R4: For a fetch (`req_kind` = 2'b00), `psen_n` is low in phases 3, 4 and 5 only, and `ad_oe` is 0 from phase 2 onward.
- R5: For a read (`req_kind` = 2'b01), `rd_n` is low in phases 3, 4 and 5 only, and `ad_oe` is 0 from phase 2 onward.
- R6: For a write (`req_kind` = 2'b10), `wr_n` is low in phases 3, 4 and 5 only. In phases 2 to 5, `ad_oe` is 1 and `ad_out` carries the write byte, which starts after `ale` has fallen.
- R7: For a fetch or read, the `ad_in` value present in phase 5 is returned on `rsp_data`, with `rsp_valid` high for phase 6 only. Writes and idle cycles never raise `rsp_valid`.
- R8: At most one of `psen_n`, `rd_n` and `wr_n` is low at any time. The request code 2'b11 is accepted but runs as an idle cycle. In an idle cycle all three strobes stay high, `ad_oe` is 0 and `ad_out` is 0.
- R9: While `rst` is high, `ale` is 0, all three strobes are 1, `ad_oe`, `rsp_valid`, `req_ready` and `addr_hi` are 0. The first clock after `rst` falls is phase 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge (last phase) |
| req_kind | input | 2 | 00 fetch, 01 read, 10 write, 11 idle |
| req_addr | input | AW | Bus address |
| req_wdata | input | DW | Write byte |
| rsp_valid | output | 1 | Read/fetch byte valid (one clock) |
| rsp_data | output | DW | Read/fetch byte |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Code fetch strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | DW | Low address / write data, outgoing |
| ad_oe | output | 1 | Drive enable for the shared pins |
| ad_in | input | DW | Shared pins, incoming |
| addr_hi | output | AW-DW | High address byte |

## Verification
The bench builds the block with its defaults: a twelve-clock cycle, 16-bit addresses and 8-bit data. With these values every phase of every transaction kind occurs within a few hundred clocks, and the address ends 0x0000 and 0xFFFF reach both `ad_out` and `addr_hi`. Random mixes of fetch, read, write, the unused code and empty cycles give back-to-back transactions of different kinds, which exposes any strobe or data-pin drive that leaks from one cycle into the next.

// File: rtl/bct_pkg.sv
package bct_pkg;
  typedef enum logic [1:0] {
    BK_FETCH = 2'd0,
    BK_READ  = 2'd1,
    BK_WRITE = 2'd2,
    BK_NONE  = 2'd3
  } bus_kind_e;
endpackage

// File: rtl/bct_phase.sv
module bct_phase #(
  parameter int CYC_LEN = 12,
  parameter int PW      = $clog2(CYC_LEN)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          run,
  output logic [PW-1:0] phase,
  output logic          last
);
  localparam logic [PW-1:0] P_LAST = PW'(CYC_LEN - 1);

  logic          run_q;
  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q   <= 1'b0;
      phase_q <= '0;
    end else if (!run_q) begin
      run_q   <= 1'b1;
      phase_q <= '0;
    end else if (phase_q == P_LAST) begin
      phase_q <= '0;
    end else begin
      phase_q <= phase_q + 1'b1;
    end
  end

  assign run   = run_q;
  assign phase = phase_q;
  assign last  = run_q && (phase_q == P_LAST);
endmodule

// File: rtl/bct_slot.sv
module bct_slot
  import bct_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          take,
  input  logic          req_valid,
  input  logic [1:0]    req_kind,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          live,
  output bus_kind_e     kind,
  output logic [AW-1:0] addr,
  output logic [DW-1:0] wdata
);
  logic          live_q;
  bus_kind_e     kind_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q  <= 1'b0;
      kind_q  <= BK_NONE;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (take) begin
      live_q <= req_valid && (bus_kind_e'(req_kind) != BK_NONE);
      if (req_valid) begin
        kind_q  <= bus_kind_e'(req_kind);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
    end
  end

  assign live  = live_q;
  assign kind  = kind_q;
  assign addr  = addr_q;
  assign wdata = wdata_q;
endmodule

// File: rtl/bct_decode.sv
module bct_decode
  import bct_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int PW      = $clog2(CYC_LEN),
  parameter int AW      = 16,
  parameter int DW      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PW-1:0]    phase,
  input  logic             live,
  input  bus_kind_e        kind,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    ad_in,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic             ad_oe,
  output logic [DW-1:0]    ad_out,
  output logic [AW-DW-1:0] addr_hi,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data
);
  localparam int HALF  = CYC_LEN / 2;
  localparam int ALE_W = CYC_LEN / 6;
  localparam logic [PW-1:0] P_ALE1_END = PW'(ALE_W);
  localparam logic [PW-1:0] P_ALE2_BEG = PW'(HALF);
  localparam logic [PW-1:0] P_ALE2_END = PW'(HALF + ALE_W);
  localparam logic [PW-1:0] P_STB_BEG  = PW'(ALE_W + 1);
  localparam logic [PW-1:0] P_STB_END  = PW'(HALF - 1);

  logic in_addr, in_data, in_strobe, in_ale;
  logic is_fetch, is_read, is_write;
  logic          rsp_valid_q;
  logic [DW-1:0] rsp_data_q;

  always_comb begin
    in_ale    = run && ((phase < P_ALE1_END) ||
                        ((phase >= P_ALE2_BEG) && (phase < P_ALE2_END)));
    in_addr   = run && live && (phase < P_ALE1_END);
    in_data   = run && live && (phase >= P_ALE1_END) && (phase <= P_STB_END);
    in_strobe = run && live && (phase >= P_STB_BEG) && (phase <= P_STB_END);
    is_fetch  = (kind == BK_FETCH);
    is_read   = (kind == BK_READ);
    is_write  = (kind == BK_WRITE);
  end

  always_comb begin
    ale    = in_ale;
    psen_n = !(in_strobe && is_fetch);
    rd_n   = !(in_strobe && is_read);
    wr_n   = !(in_strobe && is_write);
    ad_oe  = in_addr || (in_data && is_write);
    if (in_addr)                 ad_out = addr[DW-1:0];
    else if (in_data && is_write) ad_out = wdata;
    else                         ad_out = '0;
    addr_hi = addr[AW-1:DW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (in_strobe && (phase == P_STB_END) && (is_fetch || is_read)) begin
        rsp_valid_q <= 1'b1;
        rsp_data_q  <= ad_in;
      end
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;
endmodule

// File: rtl/bus_cycle_timer.sv
module bus_cycle_timer
  import bct_pkg::*;
#(
  parameter int CYC_LEN = 12,
  parameter int AW      = 16,
  parameter int DW      = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_kind,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data,
  output logic             ale,
  output logic             psen_n,
  output logic             rd_n,
  output logic             wr_n,
  output logic [DW-1:0]    ad_out,
  output logic             ad_oe,
  input  logic [DW-1:0]    ad_in,
  output logic [AW-DW-1:0] addr_hi
);
  localparam int PW = $clog2(CYC_LEN);

  logic          run, last, live;
  logic [PW-1:0] phase;
  bus_kind_e     kind;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;

  bct_phase #(.CYC_LEN(CYC_LEN), .PW(PW)) u_phase (
    .clk(clk), .rst(rst), .run(run), .phase(phase), .last(last)
  );

  bct_slot #(.AW(AW), .DW(DW)) u_slot (
    .clk(clk), .rst(rst), .take(last), .req_valid(req_valid),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .live(live), .kind(kind), .addr(addr), .wdata(wdata)
  );

  bct_decode #(.CYC_LEN(CYC_LEN), .PW(PW), .AW(AW), .DW(DW)) u_dec (
    .clk(clk), .rst(rst), .run(run), .phase(phase), .live(live),
    .kind(kind), .addr(addr), .wdata(wdata), .ad_in(ad_in),
    .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
    .ad_oe(ad_oe), .ad_out(ad_out), .addr_hi(addr_hi),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data)
  );

  assign req_ready = last;
endmodule

// File: rtl/bus_cycle_timer_chk.sv
module bus_cycle_timer_chk #(
  parameter int CYC_LEN = 12
) (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_valid,
  input logic ale,
  input logic psen_n,
  input logic rd_n,
  input logic wr_n,
  input logic ad_oe
);
  localparam int HALF  = CYC_LEN / 2;
  localparam int ALE_W = CYC_LEN / 6;

  logic [7:0] since_rise, high_run;
  logic       seen_rise, ale_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rise <= '0;
      high_run   <= '0;
      seen_rise  <= 1'b0;
      ale_d      <= 1'b0;
    end else begin
      ale_d    <= ale;
      high_run <= ale ? ((high_run == 8'hFF) ? high_run : high_run + 8'd1) : 8'd0;
      if (ale && !ale_d) begin
        since_rise <= 8'd1;
        seen_rise  <= 1'b1;
      end else if (since_rise != 8'hFF) begin
        since_rise <= since_rise + 8'd1;
      end
    end
  end

  AST_ALE_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (ale && !ale_d && seen_rise) |-> (since_rise == 8'(HALF))); // R2
  AST_ALE_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!ale && ale_d) |-> (high_run == 8'(ALE_W))); // R2
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $countones({~psen_n, ~rd_n, ~wr_n}) <= 1); // R8
  AST_STROBE_NO_ALE: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n || !wr_n) |-> !ale); // R2
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
    (!psen_n || !rd_n) |-> !ad_oe); // R5
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!ale && psen_n && rd_n && wr_n)); // R1
  AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (!$past(psen_n) || !$past(rd_n))); // R7
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!ale && psen_n && rd_n && wr_n && !ad_oe && !req_ready)); // R9
endmodule

bind bus_cycle_timer bus_cycle_timer_chk #(.CYC_LEN(CYC_LEN)) u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_oe(ad_oe)
);

// File: tb/sim_bus_cycle_timer.sv
module sim_bus_cycle_timer;
  localparam int CYC = 12;
  localparam int AW  = 16;
  localparam int DW  = 8;
  localparam int NCYC = 400;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst, req_valid, req_ready, rsp_valid;
  logic [1:0]    req_kind;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata, rsp_data, ad_out, ad_in;
  logic          ale, psen_n, rd_n, wr_n, ad_oe;
  logic [AW-DW-1:0] addr_hi;

  bus_cycle_timer #(.CYC_LEN(CYC), .AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .ale(ale),
    .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out),
    .ad_oe(ad_oe), .ad_in(ad_in), .addr_hi(addr_hi)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;

  task automatic chk(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic bit exp_ale(int ph);
    return (ph < 2) || (ph >= 6 && ph < 8);
  endfunction

  function automatic bit exp_strobe_n(int ph, bit act, logic [1:0] k, logic [1:0] want);
    return !(act && k == want && ph >= 3 && ph <= 5);
  endfunction

  function automatic bit exp_oe(int ph, bit act, logic [1:0] k);
    return act && (ph < 2 || (k == 2'b10 && ph >= 2 && ph <= 5));
  endfunction

  task automatic check_reset();
    chk("R9 ale", 16'(ale), 16'h0);
    chk("R9 strobes", 16'({psen_n, rd_n, wr_n}), 16'h7);
    chk("R9 ad_oe", 16'(ad_oe), 16'h0);
    chk("R9 rsp_valid", 16'(rsp_valid), 16'h0);
    chk("R9 req_ready", 16'(req_ready), 16'h0);
    chk("R9 addr_hi", 16'(addr_hi), 16'h0);
  endtask

  task automatic pick_request(int n);
    logic [1:0] dk [8];
    logic [15:0] da [8];
    logic [7:0] dw [8];
    dk = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00, 2'b10, 2'b01, 2'b00};
    da = '{16'h0000, 16'hFFFF, 16'h12AB, 16'h5A5A, 16'hFF00, 16'h00FF, 16'h8001, 16'h7FFE};
    dw = '{8'h00, 8'h11, 8'hFF, 8'h22, 8'h33, 8'h00, 8'h44, 8'h55};
    if (n < 8) begin
      req_valid = (n != 6) ? 1'b1 : 1'b0;
      req_kind  = dk[n];
      req_addr  = da[n];
      req_wdata = dw[n];
    end else begin
      req_valid = ($urandom_range(0, 9) < 8);
      req_kind  = 2'($urandom_range(0, 3));
      req_addr  = 16'($urandom);
      req_wdata = 8'($urandom);
    end
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int ph, mcyc;
    bit cur_act;
    logic [1:0] cur_kind;
    logic [15:0] cur_addr;
    logic [7:0] cur_wd, cap;
    bit e_oe, e_rsp;
    logic [7:0] e_ad;
    void'($urandom(32'h0BC7_51A3));
    rst = 1'b1; req_valid = 1'b0; req_kind = 2'b00;
    req_addr = '0; req_wdata = '0; ad_in = '0;
    repeat (3) @(negedge clk);
    check_reset();
    rst = 1'b0;
    ph = 0; mcyc = 0; cur_act = 0; cur_kind = 2'b11;
    cur_addr = '0; cur_wd = '0; cap = '0;
    for (int n = 0; n < NCYC * CYC; n++) begin
      @(negedge clk);
      // R1 ready in last phase only; R2 ale windows
      chk("R1 req_ready", 16'(req_ready), 16'(ph == CYC - 1));
      chk("R2 ale", 16'(ale), 16'(exp_ale(ph)));
      chk(cur_act ? "R4 psen_n" : "R8 psen_n idle", 16'(psen_n),
          16'(exp_strobe_n(ph, cur_act, cur_kind, 2'b00)));
      chk(cur_act ? "R5 rd_n" : "R8 rd_n idle", 16'(rd_n),
          16'(exp_strobe_n(ph, cur_act, cur_kind, 2'b01)));
      chk(cur_act ? "R6 wr_n" : "R8 wr_n idle", 16'(wr_n),
          16'(exp_strobe_n(ph, cur_act, cur_kind, 2'b10)));
      e_oe = exp_oe(ph, cur_act, cur_kind);
      e_ad = !e_oe ? 8'h00 : (ph < 2 ? cur_addr[7:0] : cur_wd);
      chk(!cur_act ? "R8 ad_oe idle" : (ph < 2 ? "R3 ad_oe" : "R6 ad_oe"),
          16'(ad_oe), 16'(e_oe));
      chk(!cur_act ? "R8 ad_out idle" : (ph < 2 ? "R3 ad_out" : "R6 ad_out"),
          16'(ad_out), 16'(e_ad));
      if (cur_act) chk("R3 addr_hi", 16'(addr_hi), 16'(cur_addr[15:8]));
      e_rsp = (ph == 6) && cur_act && (cur_kind != 2'b10);
      chk("R7 rsp_valid", 16'(rsp_valid), 16'(e_rsp));
      if (e_rsp) chk("R7 rsp_data", 16'(rsp_data), 16'(cap));
      // drive new inputs
      ad_in = 8'($urandom);
      if (ph == 0) begin
        pick_request(mcyc);
        mcyc++;
      end
      if (ph == 5) cap = ad_in;
      if (ph == CYC - 1) begin
        cur_act  = req_valid && (req_kind != 2'b11);
        cur_kind = req_kind;
        cur_addr = req_addr;
        cur_wd   = req_wdata;
      end
      ph = (ph + 1) % CYC;
    end
    // second reset in mid-run
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check_reset();
    @(negedge clk);
    check_reset();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule